// File: doc/BRIEF.md
# Dual Frame Buffer Pixel Fetcher

This block pulls pixel words out of memory for a raster display pipeline. Software programs two address windows, each given by a start address and an end address that lies one byte past the last pixel byte. The end address is the start plus the frame size, and the frame size in bytes is width times height times bits per pixel divided by eight. The fetcher walks the first window word by word, then the second, then the first again, and so on. It emits a one-cycle pulse each time a window has been fully read.

Reads leave the block as bursts on a request/grant port. The burst length comes from a 3-bit code, and no burst runs past the end of the current window. Returned words go into a pixel FIFO, and they reach the raster side on a valid/ready stream. Fetching is paced in two ways. A 3-bit threshold sets how full the FIFO may get before new bursts stop. A programmed 8-bit count delays the first request after the block is switched on.

Top module: `fb_fetch_dma`

## Requirements
- R1: While reset is held and right after it is released, mem_req, pix_valid and frame_done are low.
- R2: Burst code 0, 1, 2, 3 and 4 requests bursts of 1, 2, 4, 8 and 16 words. The length appears on mem_len as a plain word count, unless R4 trims it.
- R3: Burst codes 5, 6 and 7 each request a burst of 16 words, unless R4 trims it.
- R4: A burst never reaches past the end address of its window. When fewer words remain than the code selects, the burst carries exactly (end - address) / 4 words.
- R5: After enable, fetching starts at the start address of window 0. Each burst begins at the byte address directly after the previous burst, in steps of 4 bytes per word.
- R6: Once the last word of a window has been returned, fetching moves on to the start of the other window. frame_done is high for exactly one cycle per completed window.
- R7: Once mem_req is raised, it stays high with mem_addr and mem_len unchanged until the cycle in which mem_gnt is sampled high.
- R8: A new burst is requested only when the number of words held in the FIFO is below (threshold + 1) * 4. The words held plus the burst length must also not exceed the FIFO depth of 32.
- R9: With an empty FIFO, if enable is first sampled high at clock edge 0, then mem_req first goes high right after edge req_delay + 2.
- R10: Pixel words leave on pix_data in the order they were fetched. Each word is held steady while pix_valid is high and pix_ready is low.
- R11: When enable is low, any burst in flight is finished, then the FIFO is emptied, pix_valid goes low and no new request is made. The next enable starts again at window 0 (R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run fetching; low stops and flushes |
| burst_code | input | 3 | Coded burst length |
| fifo_thresh | input | 3 | FIFO fill level code for pacing |
| req_delay | input | 8 | Cycles to hold off the first request after enable |
| win0_start | input | 32 | Start byte address of window 0 |
| win0_end | input | 32 | End byte address of window 0 (exclusive) |
| win1_start | input | 32 | Start byte address of window 1 |
| win1_end | input | 32 | End byte address of window 1 (exclusive) |
| mem_req | output | 1 | Read burst request |
| mem_addr | output | 32 | Byte address of the burst's first word |
| mem_len | output | 5 | Words in the burst |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| pix_valid | output | 1 | Pixel word available |
| pix_data | output | 32 | Pixel word |
| pix_ready | input | 1 | Consumer takes the pixel word |
| frame_done | output | 1 | One-cycle pulse per completed window |

## Verification
The bench aims at window sizes that are not a multiple of the burst length, and at one-word windows. A design that ignored the end address would read past the window and report a wrong mem_len at the last grant. Codes 5 to 7 are mixed in as well: a design that decoded them as shifts would request 32-, 64- or 128-word bursts. The bench also holds the sink slow or stalled to test the threshold. A design without the fill check would raise mem_req while the FIFO is already above its level. The post-enable delay is timed exactly at values from 0 to 255, so a delay that is off by one cycle, or one that restarts wrongly, shows up. Each run ends with a disable and a restart, which catches stale pixels and a failure to return to window 0.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READY,
        ST_REQ,
        ST_DATA
    } fbf_state_e;

endpackage

// File: rtl/fbf_burst_calc.sv
module fbf_burst_calc #(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 4,
    parameter int LEN_W    = MAX_LOG2 + 1
) (
    input  logic [2:0]        code,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] limit,
    output logic [LEN_W-1:0]  len
);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] words_left;
    logic [LEN_W-1:0]  cap;

    always_comb begin
        span       = limit - addr;
        words_left = span >> 2;
        if (code > 3'(MAX_LOG2)) begin
            cap = LEN_W'(1) << MAX_LOG2;
        end else begin
            cap = LEN_W'(1) << code;
        end
        if (words_left < ADDR_W'(cap)) begin
            len = LEN_W'(words_left);
        end else begin
            len = cap;
        end
    end

endmodule

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] store_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (push) begin
                st_d.wr = st_q.wr + 1'b1;
            end
            if (pop) begin
                st_d.rd = st_q.rd + 1'b1;
            end
            if (push && !pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop && !push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            store_q[st_q.wr] <= wdata;
        end
    end

    assign rdata = store_q[st_q.rd];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);

    // R8: the space reservation keeps writes away from a full FIFO
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CNT_W'(DEPTH)) || pop);

    // R10: nothing is popped from an empty FIFO
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/fb_fetch_dma.sv
module fb_fetch_dma #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 32,
    parameter int MAX_LOG2   = 4,
    parameter int DLY_W      = 8,
    parameter int LEN_W      = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        burst_code,
    input  logic [2:0]        fifo_thresh,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic [ADDR_W-1:0] win0_start,
    input  logic [ADDR_W-1:0] win0_end,
    input  logic [ADDR_W-1:0] win1_start,
    input  logic [ADDR_W-1:0] win1_end,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    input  logic              pix_ready,
    output logic              frame_done
);
    import fbf_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam int CW    = CNT_W + 1;
    localparam int STEP  = FIFO_DEPTH / 8;

    typedef struct packed {
        fbf_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              sel;
        logic [DLY_W-1:0]  dly;
        logic [LEN_W-1:0]  left;
        logic [LEN_W-1:0]  len;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [ADDR_W-1:0] cur_end;
    logic [ADDR_W-1:0] next_addr;
    logic [LEN_W-1:0]  blen;
    logic [CNT_W-1:0]  occ;
    logic [CW-1:0]     level;
    logic              fifo_empty;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_clear;

    assign cur_end   = c_q.sel ? win1_end : win0_end;
    assign next_addr = c_q.addr + (ADDR_W'(c_q.len) << 2);
    assign level     = CW'((32'(fifo_thresh) + 1) * STEP);

    fbf_burst_calc #(
        .ADDR_W  (ADDR_W),
        .MAX_LOG2(MAX_LOG2),
        .LEN_W   (LEN_W)
    ) u_calc (
        .code (burst_code),
        .addr (c_q.addr),
        .limit(cur_end),
        .len  (blen)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                c_d.sel  = 1'b0;
                c_d.addr = win0_start;
                if (enable) begin
                    c_d.state = ST_WAIT;
                    c_d.dly   = req_delay;
                end
            end
            ST_WAIT: begin
                if (!enable) begin
                    c_d.state = ST_IDLE;
                end else if (c_q.dly == '0) begin
                    c_d.state = ST_READY;
                end else begin
                    c_d.dly = c_q.dly - 1'b1;
                end
            end
            ST_READY: begin
                if (!enable) begin
                    c_d.state = ST_IDLE;
                end else if ((CW'(occ) < level) &&
                             (CW'(occ) + CW'(blen) <= CW'(FIFO_DEPTH))) begin
                    c_d.state = ST_REQ;
                    c_d.len   = blen;
                end
            end
            ST_REQ: begin
                if (mem_gnt) begin
                    c_d.state = ST_DATA;
                    c_d.left  = c_q.len;
                end
            end
            ST_DATA: begin
                if (mem_rvalid) begin
                    c_d.left = c_q.left - 1'b1;
                    if (c_q.left == LEN_W'(1)) begin
                        c_d.state = ST_READY;
                        if (next_addr >= cur_end) begin
                            c_d.sel  = !c_q.sel;
                            c_d.addr = c_q.sel ? win0_start : win1_start;
                            c_d.done = 1'b1;
                        end else begin
                            c_d.addr = next_addr;
                        end
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fifo_push  = mem_rvalid && (c_q.state == ST_DATA);
    assign fifo_pop   = pix_valid && pix_ready;
    assign fifo_clear = (c_q.state == ST_IDLE);

    fbf_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(fifo_clear),
        .push (fifo_push),
        .wdata(mem_rdata),
        .pop  (fifo_pop),
        .rdata(pix_data),
        .count(occ),
        .empty(fifo_empty)
    );

    assign pix_valid  = !fifo_empty;
    assign mem_req    = (c_q.state == ST_REQ);
    assign mem_addr   = c_q.addr;
    assign mem_len    = c_q.len;
    assign frame_done = c_q.done;

    // R7: request is held with stable address and length until granted
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    // R4: a requested burst ends at or before the window end
    a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr} + ({(ADDR_W-LEN_W+1)'(0), mem_len} << 2))
                    <= {1'b0, cur_end});

    // R2: burst length is never zero nor above the largest burst
    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (mem_len <= (LEN_W'(1) << MAX_LOG2)));

    // R6: frame_done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: the FIFO never holds more than its depth
    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(occ) <= CW'(FIFO_DEPTH));

    // R10: a stalled pixel word stays put unless the FIFO is being flushed
    a_r10_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready && !fifo_clear && !c_d.state[2] && c_d.state != ST_IDLE)
        |=> pix_valid && $stable(pix_data));

endmodule

// File: tb/sim_fb_fetch_dma.sv
`timescale 1ns/1ps
module sim_fb_fetch_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  burst_code = '0;
    logic [2:0]  fifo_thresh = '0;
    logic [7:0]  req_delay = '0;
    logic [31:0] win0_start = '0, win0_end = '0, win1_start = '0, win1_end = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic        pix_ready = 1'b0;
    logic        frame_done;

    fb_fetch_dma u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .burst_code(burst_code), .fifo_thresh(fifo_thresh), .req_delay(req_delay),
        .win0_start(win0_start), .win0_end(win0_end),
        .win1_start(win1_start), .win1_end(win1_end),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .frame_done(frame_done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // configuration shared with the models
    int unsigned cb0, ce0, cb1, ce1, ccode, cth;
    int sink_pct = 0;
    bit sink_on  = 1'b0;
    int restart_id = 0;

    // model state (written by the monitor only)
    int unsigned g_addr, p_addr;
    bit g_sel, p_sel;
    int occ, done_cnt, wraps, seen_id;
    bit prev_req;

    function automatic int exp_len(int unsigned code, int unsigned addr, int unsigned lim);
        int cap;
        int rem;
        cap = (code > 4) ? 16 : (1 << code);
        rem = int'((lim - addr) >> 2);
        return (rem < cap) ? rem : cap;
    endfunction

    function automatic logic [31:0] word_at(int unsigned addr);
        return addr ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 190000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    // memory model: grant and return data on falling edges
    initial begin
        bit g;
        int beats;
        int unsigned raddr;
        int unsigned laddr;
        int llen;
        g = 0; beats = 0; raddr = 0; laddr = 0; llen = 0;
        forever begin
            @(negedge clk);
            if (g) begin
                beats = llen;
                raddr = laddr;
            end
            g = 0;
            mem_gnt <= 1'b0;
            mem_rvalid <= 1'b0;
            if (beats > 0) begin
                if (($urandom % 100) < 70) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= word_at(raddr);
                    raddr += 4;
                    beats--;
                end
            end else if (mem_req && (($urandom % 100) < 60)) begin
                g = 1;
                mem_gnt <= 1'b1;
                laddr = mem_addr;
                llen  = int'(mem_len);
            end
        end
    end

    // pixel sink
    initial begin
        forever begin
            @(negedge clk);
            pix_ready <= sink_on && (($urandom % 100) < sink_pct);
        end
    end

    // monitor: samples just before each rising edge
    initial begin
        seen_id = 0; occ = 0; done_cnt = 0; wraps = 0; prev_req = 0;
        g_addr = 0; p_addr = 0; g_sel = 0; p_sel = 0;
        forever begin
            @(negedge clk);
            #8;
            if (restart_id != seen_id) begin
                seen_id = restart_id;
                g_addr = cb0; g_sel = 0; p_addr = cb0; p_sel = 0;
                occ = 0; done_cnt = 0; wraps = 0; prev_req = 0;
            end
            if (rst_n) begin
                if (mem_req && !prev_req) begin
                    chk(occ < (int'(cth) + 1) * 4, "R8", "fill below level at request", occ, (cth + 1) * 4);
                    chk(occ + int'(mem_len) <= 32, "R8", "room for burst", occ + int'(mem_len), 32);
                end
                if (mem_req && mem_gnt) begin
                    int el;
                    int unsigned lim;
                    lim = g_sel ? ce1 : ce0;
                    el = exp_len(ccode, g_addr, lim);
                    chk(mem_addr == g_addr, "R5", "burst address", mem_addr, g_addr);
                    if (el < ((ccode > 4) ? 16 : (1 << ccode)))
                        chk(int'(mem_len) == el, "R4", "trimmed burst length", mem_len, el);
                    else if (ccode > 4)
                        chk(int'(mem_len) == el, "R3", "burst length for large code", mem_len, el);
                    else
                        chk(int'(mem_len) == el, "R2", "burst length", mem_len, el);
                    g_addr = g_addr + int'(mem_len) * 4;
                    if (g_addr >= lim) begin
                        g_sel  = !g_sel;
                        g_addr = g_sel ? cb1 : cb0;
                        wraps++;
                    end
                end
                if (mem_rvalid) occ++;
                if (pix_valid && pix_ready) begin
                    chk(pix_data == word_at(p_addr), "R10", "pixel word", pix_data, word_at(p_addr));
                    occ--;
                    p_addr += 4;
                    if (p_addr >= (p_sel ? ce1 : ce0)) begin
                        p_sel  = !p_sel;
                        p_addr = p_sel ? cb1 : cb0;
                    end
                end
                if (frame_done) done_cnt++;
            end
            prev_req = mem_req;
        end
    end

    task automatic run_cfg(int unsigned code, int unsigned th, int unsigned dly,
                           int unsigned b0, int unsigned n0,
                           int unsigned b1, int unsigned n1, int pct);
        int n;
        @(negedge clk);
        burst_code  = 3'(code);
        fifo_thresh = 3'(th);
        req_delay   = 8'(dly);
        win0_start  = b0; win0_end = b0 + n0 * 4;
        win1_start  = b1; win1_end = b1 + n1 * 4;
        cb0 = b0; ce0 = b0 + n0 * 4; cb1 = b1; ce1 = b1 + n1 * 4;
        ccode = code; cth = th; sink_pct = pct;
        restart_id++;
        @(negedge clk);
        enable  = 1'b1;
        sink_on = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mem_req && n < 400);
        chk(n == int'(dly) + 3, "R9", "cycles to first request", n, dly + 3);
        while (done_cnt < 3) @(negedge clk);
        enable  = 1'b0;
        sink_on = 1'b0;
        repeat (150) @(negedge clk);
        chk(!pix_valid, "R11", "pix_valid after disable", pix_valid, 0);
        chk(!mem_req, "R11", "mem_req after disable", mem_req, 0);
        chk(done_cnt == wraps, "R6", "frame_done pulses vs windows", done_cnt, wraps);
        chk(wraps >= 3, "R6", "windows completed", wraps, 3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!mem_req && !pix_valid && !frame_done, "R1", "outputs in reset",
            {mem_req, pix_valid, frame_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
        chk(!pix_valid, "R1", "pix_valid after reset", pix_valid, 0);
        chk(!frame_done, "R1", "frame_done after reset", frame_done, 0);

        // directed corners
        run_cfg(4, 7, 0,   32'h1000, 37, 32'h8000, 16, 80);  // R4 trim
        run_cfg(7, 3, 5,   32'h2040, 40, 32'h9000, 33, 50);  // R3
        run_cfg(0, 0, 255, 32'h3000, 1,  32'hA000, 3,  90);  // one-word window
        run_cfg(2, 1, 1,   32'h4000, 50, 32'hB000, 20, 15);  // slow sink, R8
        run_cfg(5, 7, 2,   32'h5000, 17, 32'hC000, 31, 100);
        run_cfg(6, 2, 0,   32'h6000, 16, 32'hD000, 48, 40);
        // constrained random
        for (int i = 0; i < 8; i++) begin
            run_cfg($urandom % 8, $urandom % 8, $urandom % 20,
                    32'h1_0000 + ($urandom % 256) * 4, 1 + $urandom % 60,
                    32'h2_0000 + ($urandom % 256) * 4, 1 + $urandom % 60,
                    20 + $urandom % 81);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule